// File: doc/BRIEF.md
# Wide Quotient Estimator Divider

This block produces a fast approximation of the 64-bit quotient of a 128-bit dividend, supplied as a high and a low 64-bit word, by a normalized 64-bit divisor. It does not run a full 64-step long division. Instead it forms the quotient as two 32-bit digits. Each digit comes from a 64-by-32 division by the divisor's upper half only.

Between the two digits, the block computes a 128-bit partial remainder. It then walks the upper digit downwards until that remainder is no longer negative. Because each digit is guessed from a truncated divisor, the result can be slightly high. It is guaranteed to be the true truncated quotient, or at most two above it.

A caller raises `start` for one cycle with the operands valid. The block then runs on its own with `busy` high. It signals completion with a one-cycle `done`, and the estimate appears on `quotient` in that same cycle. A divisor that does not exceed the high dividend word short-cuts to an all-ones result. Typical users are normalization and division stages of extended-precision arithmetic, which then fix the last two units with a cheap remainder check.

Top module: `quot_est_div`

## Requirements
- R1: The divisor presented with an accepted `start` has its most significant bit (bit 63) set; operands that break this are outside the block's contract.
- R2: When the divisor is less than or equal to the high dividend word, the result is all ones (0xFFFFFFFFFFFFFFFF).
- R3: When the high dividend word is below the divisor, the result lies between the truncated exact quotient and that quotient plus 2, inclusive.
- R4: A `start` seen while idle is accepted, and `busy` is high in the following cycle.
- R5: A `start` raised while `busy` is high has no effect: the result delivered belongs to the operands accepted first.
- R6: `done` is high for exactly one cycle per accepted operation, with `busy` low in that cycle and the new result already on `quotient`.
- R7: `quotient` keeps its value while the block is idle, until the next operation completes.
- R8: After reset, `busy` and `done` are low and `quotient` is zero.
- R9: A saturating operation completes with `done` two clock edges after the edge that accepts `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation; sampled only while idle |
| dividendHi | input | 64 | Upper word of the 128-bit dividend |
| dividendLo | input | 64 | Lower word of the 128-bit dividend |
| divisor | input | 64 | Normalized divisor, bit 63 set |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 64 | Quotient estimate, held between operations |

## Verification
A fault in the digit divider or in the partial remainder shows up only at completion. It appears as an estimate outside the window of the exact quotient plus two, so every non-saturating random operation compares the estimate with an exact 128-bit division. A stuck correction loop, or a control state that never leaves a divide phase, shows up as a missing `done` within a bounded number of cycles. A wrong saturation decision shows up as an all-ones result where a bounded one was due, or the reverse. Saturation also has a fixed two-edge latency, so a control fault on that path is visible within a few cycles.

// File: rtl/quot_est_pkg.sv
package quot_est_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CHECK,
    S_DIV1,
    S_MUL,
    S_CORR,
    S_DIV2,
    S_LOW
  } qeState_e;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic load;
    logic divInit;
    logic divSel;   // 0: high dividend word, 1: middle remainder bits
    logic divStep;
    logic setRem;
    logic corrStep;
    logic setLow;
    logic setSat;
  } qeCtrl_t;

endpackage

// File: rtl/quot_est_digit.sv
// Iterative restoring division of a 64-bit numerator by a 32-bit denominator,
// one quotient bit per step, valid after HALF steps when num[top] < den.
module quot_est_digit #(
  parameter int HALF = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              step,
  input  logic [2*HALF-1:0] num,
  input  logic [HALF-1:0]   den,
  output logic [HALF-1:0]   quo
);
  logic [HALF-1:0] partQ, lowQ, quoQ;
  logic [HALF:0]   trial, diff;
  logic            fits;

  always_comb begin
    trial = {partQ, lowQ[HALF-1]};
    diff  = trial - {1'b0, den};
    fits  = trial >= {1'b0, den};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      partQ <= '0;
      lowQ  <= '0;
      quoQ  <= '0;
    end else if (init) begin
      partQ <= num[2*HALF-1:HALF];
      lowQ  <= num[HALF-1:0];
      quoQ  <= '0;
    end else if (step) begin
      partQ <= fits ? diff[HALF-1:0] : trial[HALF-1:0];
      lowQ  <= {lowQ[HALF-2:0], 1'b0};
      quoQ  <= {quoQ[HALF-2:0], fits};
    end
  end

  assign quo = quoQ;
endmodule

// File: rtl/quot_est_dp.sv
module quot_est_dp
  import quot_est_pkg::*;
#(
  parameter int WORD = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  qeCtrl_t         ctrl,
  input  logic [WORD-1:0] dividendHi,
  input  logic [WORD-1:0] dividendLo,
  input  logic [WORD-1:0] divisor,
  output logic            sat,
  output logic            remNeg,
  output logic [WORD-1:0] quotient
);
  localparam int HALF = WORD / 2;
  localparam int WIDE = 2 * WORD;
  localparam int PROD = WORD + HALF;

  logic [WORD-1:0] aHi, aLo, dvs, quotQ;
  logic [WIDE-1:0] rem;
  logic [HALF-1:0] zHi, zLo, digitQ, zHiSel, zLoSel;
  logic [WORD-1:0] digitNum, remMid, dvsTop;
  logic [PROD-1:0] prod;
  logic            skipHi, skipLo;

  quot_est_digit #(.HALF(HALF)) u_digit (
    .clk  (clk),
    .rst_n(rst_n),
    .init (ctrl.divInit),
    .step (ctrl.divStep),
    .num  (digitNum),
    .den  (dvs[WORD-1:HALF]),
    .quo  (digitQ)
  );

  always_comb begin
    dvsTop   = {dvs[WORD-1:HALF], {HALF{1'b0}}};
    remMid   = rem[WORD+HALF-1:HALF];
    digitNum = ctrl.divSel ? remMid : aHi;
    skipHi   = dvsTop <= aHi;
    skipLo   = dvsTop <= remMid;
    zHiSel   = skipHi ? {HALF{1'b1}} : digitQ;
    zLoSel   = skipLo ? {HALF{1'b1}} : digitQ;
    prod     = {{HALF{1'b0}}, dvs} * {{WORD{1'b0}}, zHiSel};
    sat      = dvs <= aHi;
    remNeg   = rem[WIDE-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aHi   <= '0;
      aLo   <= '0;
      dvs   <= '0;
      rem   <= '0;
      zHi   <= '0;
      zLo   <= '0;
      quotQ <= '0;
    end else begin
      if (ctrl.load) begin
        aHi <= dividendHi;
        aLo <= dividendLo;
        dvs <= divisor;
      end
      if (ctrl.setRem) begin
        zHi <= zHiSel;
        rem <= {aHi, aLo} - {prod, {HALF{1'b0}}};
      end
      if (ctrl.corrStep) begin
        zHi <= zHi - 1'b1;
        rem <= rem + {{HALF{1'b0}}, dvs, {HALF{1'b0}}};
      end
      if (ctrl.setLow) begin
        zLo   <= zLoSel;
        quotQ <= {zHi, zLoSel};
      end
      if (ctrl.setSat) quotQ <= {WORD{1'b1}};
    end
  end

  assign quotient = quotQ;
endmodule

// File: rtl/quot_est_ctl.sv
module quot_est_ctl
  import quot_est_pkg::*;
#(
  parameter int WORD = 64
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    sat,
  input  logic    remNeg,
  output qeCtrl_t ctrl,
  output logic    busy,
  output logic    done
);
  localparam int HALF = WORD / 2;
  localparam int CW   = $clog2(HALF);

  qeState_e state, nxt;
  logic [CW-1:0] cnt;
  logic lastStep, doneQ;

  assign lastStep = cnt == CW'(HALF - 1);

  always_comb begin
    ctrl = '0;
    nxt  = state;
    case (state)
      S_IDLE:  if (start) begin ctrl.load = 1'b1; nxt = S_CHECK; end
      S_CHECK: begin
        if (sat) begin
          ctrl.setSat = 1'b1;
          nxt = S_IDLE;
        end else begin
          ctrl.divInit = 1'b1;
          nxt = S_DIV1;
        end
      end
      S_DIV1: begin
        ctrl.divStep = 1'b1;
        if (lastStep) nxt = S_MUL;
      end
      S_MUL: begin
        ctrl.setRem = 1'b1;
        nxt = S_CORR;
      end
      S_CORR: begin
        if (remNeg) begin
          ctrl.corrStep = 1'b1;
        end else begin
          ctrl.divInit = 1'b1;
          ctrl.divSel  = 1'b1;
          nxt = S_DIV2;
        end
      end
      S_DIV2: begin
        ctrl.divStep = 1'b1;
        if (lastStep) nxt = S_LOW;
      end
      S_LOW: begin
        ctrl.setLow = 1'b1;
        nxt = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
      doneQ <= 1'b0;
    end else begin
      state <= nxt;
      doneQ <= ctrl.setSat | ctrl.setLow;
      if (ctrl.divInit) cnt <= '0;
      else if (ctrl.divStep) cnt <= cnt + 1'b1;
    end
  end

  assign busy = state != S_IDLE;
  assign done = doneQ;
endmodule

// File: rtl/quot_est_div.sv
module quot_est_div
  import quot_est_pkg::*;
#(
  parameter int WORD = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [WORD-1:0] dividendHi,
  input  logic [WORD-1:0] dividendLo,
  input  logic [WORD-1:0] divisor,
  output logic            busy,
  output logic            done,
  output logic [WORD-1:0] quotient
);
  qeCtrl_t ctrl;
  logic    sat, remNeg;

  quot_est_ctl #(.WORD(WORD)) u_ctl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .sat   (sat),
    .remNeg(remNeg),
    .ctrl  (ctrl),
    .busy  (busy),
    .done  (done)
  );

  quot_est_dp #(.WORD(WORD)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl      (ctrl),
    .dividendHi(dividendHi),
    .dividendLo(dividendLo),
    .divisor   (divisor),
    .sat       (sat),
    .remNeg    (remNeg),
    .quotient  (quotient)
  );
endmodule

// File: rtl/quot_est_checks.sv
module quot_est_checks #(
  parameter int WORD = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic [WORD-1:0] divisor,
  input logic            busy,
  input logic            done,
  input logic [WORD-1:0] quotient
);
  p_norm_divisor_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |-> divisor[WORD-1]);

  p_busy_on_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_done_after_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));

  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(quotient));
endmodule

bind quot_est_div quot_est_checks #(.WORD(WORD)) u_checks (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .divisor (divisor),
  .busy    (busy),
  .done    (done),
  .quotient(quotient)
);

// File: tb/sim_quot_est_div.sv
`timescale 1ns/1ps
module sim_quot_est_div;
  localparam int WORD = 64;
  localparam int WATCHDOG = 150000;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [WORD-1:0] dividendHi = '0, dividendLo = '0, divisor = '0;
  logic            busy, done;
  logic [WORD-1:0] quotient;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  quot_est_div #(.WORD(WORD)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .dividendHi(dividendHi), .dividendLo(dividendLo), .divisor(divisor),
    .busy(busy), .done(done), .quotient(quotient)
  );

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WATCHDOG) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles, expected under %0d", cycles, WATCHDOG);
      finishRun();
    end
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [64:0] exactQ(input logic [63:0] hi, input logic [63:0] lo, input logic [63:0] d);
    logic [127:0] q;
    q = {hi, lo} / {64'd0, d};
    return q[64:0];
  endfunction

  function automatic logic [63:0] rand64();
    return {$urandom(), $urandom()};
  endfunction

  // Issue one operation and wait for done; returns cycles from accept edge to done sample.
  task automatic runOp(input logic [63:0] hi, input logic [63:0] lo, input logic [63:0] d,
                       input bit disturb, output logic [63:0] est, output int lat);
    dividendHi = hi; dividendLo = lo; divisor = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    chk(busy === 1'b1, "R4 busy after start", {127'd0, busy}, 128'd1);
    if (disturb) begin
      // R5: second request while busy, with saturating operands
      dividendHi = 64'hFFFF_FFFF_FFFF_FFFF; divisor = 64'h8000_0000_0000_0000; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat++;
    end
    while (done !== 1'b1 && lat < 400) begin
      @(negedge clk);
      lat++;
    end
    chk(done === 1'b1 && busy === 1'b0, "R6 done with busy low", {126'd0, done, busy}, 128'd2);
    est = quotient;
  endtask

  task automatic checkBound(input logic [63:0] hi, input logic [63:0] lo, input logic [63:0] d,
                            input logic [63:0] est, input string req);
    logic [64:0] q;
    q = exactQ(hi, lo, d);
    chk(({1'b0, est} >= q) && ({1'b0, est} <= q + 65'd2), req, {64'd0, est}, {63'd0, q});
  endtask

  initial begin
    logic [63:0] est, hi, lo, d, held;
    int lat;
    void'($urandom(32'h5EED_0042));

    repeat (3) @(negedge clk);
    // R8: reset state
    chk(busy === 1'b0, "R8 busy at reset", {127'd0, busy}, 128'd0);
    chk(done === 1'b0, "R8 done at reset", {127'd0, done}, 128'd0);
    chk(quotient === 64'd0, "R8 quotient at reset", {64'd0, quotient}, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R9: saturation with divisor equal to high word, latency two edges
    runOp(64'h9000_0000_0000_0001, 64'h1234, 64'h9000_0000_0000_0001, 1'b0, est, lat);
    chk(est === 64'hFFFF_FFFF_FFFF_FFFF, "R2 sat equal", {64'd0, est}, {64'd0, 64'hFFFF_FFFF_FFFF_FFFF});
    chk(lat == 2, "R9 sat latency", 128'(lat), 128'd2);
    // R6: done falls next cycle; R7: quotient held while idle
    held = quotient;
    @(negedge clk);
    chk(done === 1'b0, "R6 done single cycle", {127'd0, done}, 128'd0);
    repeat (5) @(negedge clk);
    chk(quotient === held, "R7 quotient held", {64'd0, quotient}, {64'd0, held});

    // R2: high word above divisor
    runOp(64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 64'h8000_0000_0000_0000, 1'b0, est, lat);
    chk(est === 64'hFFFF_FFFF_FFFF_FFFF, "R2 sat above", {64'd0, est}, {64'd0, 64'hFFFF_FFFF_FFFF_FFFF});

    // R3 directed corners
    runOp(64'd0, 64'd0, 64'h8000_0000_0000_0000, 1'b0, est, lat);
    checkBound(64'd0, 64'd0, 64'h8000_0000_0000_0000, est, "R3 zero dividend");
    runOp(64'h8000_0000_0000_0000 - 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 1'b0, est, lat);
    checkBound(64'h7FFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, est, "R3 min divisor max q");
    runOp(64'hFFFF_FFFF_FFFF_FFFE, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, est, lat);
    checkBound(64'hFFFF_FFFF_FFFF_FFFE, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, est, "R3 max divisor");
    runOp(64'h8000_0000_FFFF_FFFF, 64'h0, 64'h8000_0001_0000_0000, 1'b0, est, lat);
    checkBound(64'h8000_0000_FFFF_FFFF, 64'h0, 64'h8000_0001_0000_0000, est, "R3 top-half skip");

    // R5: start while busy is ignored
    hi = 64'h0000_0000_0000_0123; lo = 64'h4567_89AB_CDEF_0000; d = 64'hC000_0000_0000_0001;
    runOp(hi, lo, d, 1'b1, est, lat);
    checkBound(hi, lo, d, est, "R5 start ignored while busy");
    @(negedge clk);
    chk(busy === 1'b0, "R5 no second run", {127'd0, busy}, 128'd0);

    // R3 random
    for (int i = 0; i < 250; i++) begin
      d  = rand64() | 64'h8000_0000_0000_0000;
      if (i % 5 == 0) d = {32'h8000_0000 | $urandom(), 32'hFFFF_FFFF};
      hi = rand64() % d;
      if (i % 7 == 0) hi = d - 64'(($urandom() % 3) + 1);
      lo = rand64();
      runOp(hi, lo, d, 1'b0, est, lat);
      checkBound(hi, lo, d, est, "R3 random bound");
      // R1 usage: every divisor here is normalized
      @(negedge clk);
    end

    // R2 random saturation
    for (int i = 0; i < 20; i++) begin
      d  = rand64() | 64'h8000_0000_0000_0000;
      hi = d + (rand64() % (~d + 64'd1));
      runOp(hi, rand64(), d, 1'b0, est, lat);
      chk(est === 64'hFFFF_FFFF_FFFF_FFFF, "R2 random sat", {64'd0, est}, {64'd0, 64'hFFFF_FFFF_FFFF_FFFF});
      @(negedge clk);
    end

    finishRun();
  end
endmodule